// File: doc/BRIEF.md
# Configurable-Length Serial Data Channel

This block is the data path of one channel in a serial communication unit. A 9-bit shifter moves a word out on a serial output while it collects a word from a serial input, one bit per bit-clock tick. A 16-bit data register holds the buffer that feeds and receives the shifter in its low bits. Its top seven bits hold the divider that sets the channel's bit clock. Software reaches only the data register; the shifter is never visible on the bus.

The word length is 7, 8 or 9 bits. The 9-bit length is honoured only while the 9-bit capability input is high; without it, that length code behaves as 8 bits. A write to the buffer while the channel is enabled and idle starts a transfer. When the last bit has been shifted, the channel raises a one-cycle done pulse and places the received word in the buffer with every bit above the length cleared. Bit order changes only the order on the wire: a word occupies the same register bits in both orders. Two bus widths exist. A 16-bit write can change the divider only while the channel is disabled. An 8-bit write reaches bits 7..0 only, and if the channel is disabled it also clears the divider.

Top module: `ser_data_chan`

## Requirements
- R1: After reset, `bus_rdata` is 0x0000, and `busy`, `done`, `bit_tick` and `ser_out` are all 0.
- R2: The word length is 7 bits for `len_sel`=0, 8 bits for `len_sel`=1 or 3, and 9 bits for `len_sel`=2 only when `uart9_en`=1. With `len_sel`=2 and `uart9_en`=0 the length is 8 bits.
- R3: A 16-bit write (`bus_wr`=1, `bus_wide`=1) loads `bus_wdata[8:0]` into buffer bits 8..0. It loads `bus_wdata[15:9]` into divider bits 15..9 only when `chan_en`=0; when `chan_en`=1 the divider keeps its value.
- R4: An 8-bit write (`bus_wr`=1, `bus_wide`=0) loads `bus_wdata[7:0]` into bits 7..0 and leaves bit 8 unchanged. With `chan_en`=0 it clears bits 15..9 in the same cycle; with `chan_en`=1 it leaves them unchanged.
- R5: Any write while `chan_en`=1 and `busy`=0 starts a transfer of the new buffer value masked to the word length, and `busy` is 1 from the next cycle. A write while `busy`=1 updates the buffer but does not restart the transfer or change its timing.
- R6: During a transfer, `bit_tick` is high for one cycle in every (D+1)*2 cycles, where D is bits 15..9. The k-th tick (k counted from 1) comes k*(D+1)*2-1 clock edges after the starting edge. `bit_tick` is never high while `busy`=0.
- R7: With `msb_first`=0 the word is sent bit 0 first; with `msb_first`=1 it is sent bit L-1 first, where L is the length. Each bit is present on `ser_out` in the cycle in which its tick is high.
- R8: `ser_in` is sampled at each tick edge. With `msb_first`=0 the first sampled bit lands in bit 0; with `msb_first`=1 it lands in bit L-1. A word therefore has the same bit positions in both orders.
- R9: L*(D+1)*2 edges after the start, `done` is high for exactly one cycle and `busy` is 0. The buffer then holds the received word, and every bit from L to 8 reads 0.
- R10: `bus_rdata` always shows the full register: divider in bits 15..9 and buffer in bits 8..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_en | input | 1 | Channel enable; 0 allows divider updates |
| uart9_en | input | 1 | Permits the 9-bit word length |
| len_sel | input | 2 | Word length code |
| msb_first | input | 1 | 1 sends and receives the most significant bit first |
| bus_wr | input | 1 | Write strobe for the data register |
| bus_wide | input | 1 | 1 selects a 16-bit write, 0 an 8-bit write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Data register contents |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| bit_tick | output | 1 | Bit-clock strobe, one cycle wide |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench sweeps every length code with the capability input both high and low. It covers both bit orders and several divider values, and drives a different receive pattern for every transfer. A design that ignored the capability input would store a ninth bit. A design that did not zero-fill would leave stale transmit bits above a 7-bit word. A design that mirrored MSB-first data would receive a reversed word. A late or early terminal count in the divider would move every tick off its computed edge. Separate cases cover divider clearing on an 8-bit write while disabled, divider retention on writes while enabled, and a buffer write in the middle of a transfer. A wrong design would restart the shift on that mid-transfer write or lose bit 8.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int SHIFT_W = 9;
  localparam int DIV_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int LEN_W   = 4;

  typedef enum logic [1:0] {
    LEN_CODE_7  = 2'd0,
    LEN_CODE_8  = 2'd1,
    LEN_CODE_9  = 2'd2,
    LEN_CODE_8B = 2'd3
  } len_code_e;
endpackage

// File: rtl/sdc_len_decode.sv
module sdc_len_decode
  import sdc_pkg::*;
#(
  parameter int SW = SHIFT_W,
  parameter int LW = LEN_W
) (
  input  logic [1:0]    len_sel,
  input  logic          uart9_en,
  output logic [LW-1:0] len,
  output logic [SW-1:0] mask
);
  always_comb begin
    case (len_code_e'(len_sel))
      LEN_CODE_7: len = LW'(SW - 2);
      LEN_CODE_9: len = uart9_en ? LW'(SW) : LW'(SW - 1);
      default:    len = LW'(SW - 1);
    endcase
  end

  for (genvar i = 0; i < SW; i++) begin : g_mask
    assign mask[i] = (LW'(i) < len);
  end
endmodule

// File: rtl/sdc_bit_clock.sv
module sdc_bit_clock #(
  parameter int DW = 7,
  localparam int CW = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] terminal;

  assign terminal = {1'b0, div, 1'b1};
  assign tick     = run && (cnt_q == terminal);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdc_shifter.sv
module sdc_shifter #(
  parameter int SW = 9,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_word,
  input  logic          tick,
  input  logic          msb_first,
  input  logic [LW-1:0] len,
  input  logic [SW-1:0] mask,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          last,
  output logic [SW-1:0] rx_word
);
  logic [SW-1:0] sh_q, sh_d, shifted;
  logic [LW-1:0] bcnt_q, bcnt_d;
  logic          top_bit;

  always_comb begin
    top_bit = 1'b0;
    for (int i = 0; i < SW; i++) begin
      if (LW'(i + 1) == len) top_bit = sh_q[i];
    end
  end

  assign ser_out = msb_first ? top_bit : sh_q[0];

  always_comb begin
    if (msb_first) begin
      shifted = {sh_q[SW-2:0], ser_in} & mask;
    end else begin
      shifted = sh_q >> 1;
      for (int i = 0; i < SW; i++) begin
        if (LW'(i + 1) == len) shifted[i] = ser_in;
      end
    end
  end

  assign rx_word = shifted & mask;
  assign last    = (bcnt_q + LW'(1)) == len;

  always_comb begin
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    if (load) begin
      sh_d   = load_word & mask;
      bcnt_d = '0;
    end else if (tick) begin
      sh_d   = shifted;
      bcnt_d = bcnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
    end
  end
endmodule

// File: rtl/sdc_data_reg.sv
module sdc_data_reg #(
  parameter int SW = 9,
  parameter int DW = 7,
  parameter int BW = 8,
  localparam int RW = SW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          bus_wr,
  input  logic          bus_wide,
  input  logic [RW-1:0] bus_wdata,
  input  logic          capture,
  input  logic [SW-1:0] cap_word,
  output logic [SW-1:0] wr_buf,
  output logic [DW-1:0] div,
  output logic [RW-1:0] reg_out
);
  logic [SW-1:0] buf_q, buf_d;
  logic [DW-1:0] div_q, div_d;

  assign wr_buf = bus_wide ? bus_wdata[SW-1:0]
                           : {buf_q[SW-1:BW], bus_wdata[BW-1:0]};

  always_comb begin
    buf_d = buf_q;
    div_d = div_q;
    if (capture)     buf_d = cap_word;
    else if (bus_wr) buf_d = wr_buf;
    if (bus_wr && !chan_en) begin
      div_d = bus_wide ? bus_wdata[RW-1:SW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      div_q <= '0;
    end else begin
      buf_q <= buf_d;
      div_q <= div_d;
    end
  end

  assign div     = div_q;
  assign reg_out = {div_q, buf_q};
endmodule

// File: rtl/ser_data_chan.sv
module ser_data_chan
  import sdc_pkg::*;
#(
  parameter int SW = SHIFT_W,
  parameter int DW = DIV_W,
  parameter int BW = BYTE_W,
  parameter int LW = LEN_W,
  localparam int RW = SW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          uart9_en,
  input  logic [1:0]    len_sel,
  input  logic          msb_first,
  input  logic          bus_wr,
  input  logic          bus_wide,
  input  logic [RW-1:0] bus_wdata,
  output logic [RW-1:0] bus_rdata,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          bit_tick,
  output logic          busy,
  output logic          done
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          busy_q, busy_d, done_q, done_d;
  logic          start, finish, tick, last;
  logic [LW-1:0] len;
  logic [SW-1:0] mask, wr_buf, rx_word;
  logic [DW-1:0] div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdc_len_decode #(.SW(SW), .LW(LW)) u_len (
    .len_sel (len_sel),
    .uart9_en(uart9_en),
    .len     (len),
    .mask    (mask)
  );

  sdc_data_reg #(.SW(SW), .DW(DW), .BW(BW)) u_reg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chan_en  (chan_en),
    .bus_wr   (bus_wr),
    .bus_wide (bus_wide),
    .bus_wdata(bus_wdata),
    .capture  (finish),
    .cap_word (rx_word),
    .wr_buf   (wr_buf),
    .div      (div),
    .reg_out  (bus_rdata)
  );

  sdc_bit_clock #(.DW(DW)) u_clk (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (busy_q),
    .div  (div),
    .tick (tick)
  );

  sdc_shifter #(.SW(SW), .LW(LW)) u_sh (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (start),
    .load_word(wr_buf),
    .tick     (tick),
    .msb_first(msb_first),
    .len      (len),
    .mask     (mask),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .last     (last),
    .rx_word  (rx_word)
  );

  assign start  = chan_en && bus_wr && !busy_q;
  assign finish = tick && last;

  always_comb begin
    busy_d = busy_q;
    if (start)       busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign bit_tick = tick;
endmodule

// File: rtl/ser_data_chan_chk.sv
module ser_data_chan_chk #(
  parameter int SW = 9,
  parameter int DW = 7,
  localparam int RW = SW + DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          uart9_en,
  input logic [1:0]    len_sel,
  input logic          bus_wr,
  input logic          bus_wide,
  input logic [RW-1:0] bus_rdata,
  input logic          bit_tick,
  input logic          busy,
  input logic          done
);
  AST_TICK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> busy); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_ZERO_FILL_7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len_sel == 2'd0) |-> (bus_rdata[SW-1:SW-2] == 2'b00)); // R9
  AST_NINTH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(len_sel == 2'd2 && uart9_en)) |-> !bus_rdata[SW-1]); // R2
  AST_NARROW_CLEARS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wide && !chan_en) |=> (bus_rdata[RW-1:SW] == '0)); // R4
  AST_DIV_HELD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> (bus_rdata[RW-1:SW] == $past(bus_rdata[RW-1:SW]))); // R3
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && bus_wr && !busy) |=> busy); // R5
endmodule

bind ser_data_chan ser_data_chan_chk #(.SW(SW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .uart9_en (uart9_en),
  .len_sel  (len_sel),
  .bus_wr   (bus_wr),
  .bus_wide (bus_wide),
  .bus_rdata(bus_rdata),
  .bit_tick (bit_tick),
  .busy     (busy),
  .done     (done)
);

// File: tb/tb_ser_data_chan.sv
`timescale 1ns/1ps
module tb_ser_data_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, uart9_en = 1'b0, msb_first = 1'b0;
  logic [1:0]  len_sel = 2'd0;
  logic        bus_wr = 1'b0, bus_wide = 1'b0, ser_in = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ser_out, bit_tick, busy, done;

  int errors = 0, checks = 0, pcnt = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [6:0]  m_div = '0;
  logic [8:0]  m_buf = '0;

  always #4 clk = ~clk;
  always @(posedge clk) pcnt <= pcnt + 1;

  ser_data_chan dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .uart9_en(uart9_en),
    .len_sel(len_sel), .msb_first(msb_first), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_in(ser_in), .ser_out(ser_out), .bit_tick(bit_tick),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] rnd9();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[24:16];
  endfunction

  function automatic int len_of(input logic [1:0] s, input logic u9);
    if (s == 2'd0) return 7;
    if (s == 2'd2 && u9) return 9;
    return 8;
  endfunction

  function automatic logic [8:0] mask_of(input int l);
    return 9'((1 << l) - 1);
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic wr(input bit wide, input logic [15:0] d);
    bus_wr = 1'b1; bus_wide = wide; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_div(input logic [6:0] dv);
    chan_en = 1'b0;
    wr(1'b1, {dv, m_buf});
    m_div = dv;
    chk(bus_rdata[15:9] == dv, "R3", "divider load while disabled", bus_rdata, {dv, m_buf});
  endtask

  task automatic xfer(input logic [1:0] s, input logic u9, input logic msb,
                      input bit narrow, input logic [8:0] tx, input logic [8:0] rx);
    int l, lim, k, p0, guard;
    logic [8:0] txw, exp_rx;
    logic ebit;
    len_sel = s; uart9_en = u9; msb_first = msb; chan_en = 1'b1;
    l = len_of(s, u9);
    lim = (int'(m_div) + 1) * 2;
    if (narrow) txw = {m_buf[8], tx[7:0]} & mask_of(l);
    else        txw = tx & mask_of(l);
    wr(!narrow, {~m_div, tx});
    p0 = pcnt;
    chk(busy == 1'b1, "R5", "busy after start", busy, 1);
    chk(bus_rdata[15:9] == m_div, narrow ? "R4" : "R3", "divider kept while enabled",
        bus_rdata[15:9], m_div);
    k = 0; guard = 0;
    while (k < l && guard < 5000) begin
      ser_in = msb ? rx[l-1-k] : rx[k];
      if (bit_tick) begin
        chk(pcnt - p0 == (k + 1) * lim - 1, "R6", "tick edge", pcnt - p0, (k + 1) * lim - 1);
        ebit = msb ? txw[l-1-k] : txw[k];
        chk(ser_out == ebit, "R7", "serial output bit", ser_out, ebit);
        k++;
      end
      if (k < l) begin
        @(negedge clk);
        guard++;
      end
    end
    @(negedge clk);
    exp_rx = rx & mask_of(l);
    m_buf = exp_rx;
    chk(done == 1'b1 && busy == 1'b0, "R9", "done pulse", {done, busy}, 2'b10);
    chk(pcnt - p0 == l * lim, "R9", "transfer length in edges", pcnt - p0, l * lim);
    chk(bus_rdata == {m_div, exp_rx}, "R8", "received word and zero fill",
        bus_rdata, {m_div, exp_rx});
    @(negedge clk);
    chk(done == 1'b0, "R9", "done drops", done, 0);
  endtask

  initial begin
    int p0, l;
    logic [8:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_rdata == 16'h0000, "R1", "reset register", bus_rdata, 0);
    chk({busy, done, bit_tick, ser_out} == 4'b0, "R1", "reset outputs",
        {busy, done, bit_tick, ser_out}, 0);

    // R3 / R4 / R10: register writes while disabled
    set_div(7'd5);
    wr(1'b1, {7'd5, 9'h1C3});
    m_buf = 9'h1C3;
    chk(bus_rdata == 16'h0BC3, "R10", "full register view", bus_rdata, 16'h0BC3);
    wr(1'b0, 16'hFFA5);
    m_div = '0; m_buf = 9'h1A5;
    chk(bus_rdata == 16'h01A5, "R4", "narrow write clears divider keeps bit 8",
        bus_rdata, 16'h01A5);
    chk(busy == 1'b0, "R5", "no start while disabled", busy, 0);

    // sweep of lengths, capability, order and divider
    for (int dv = 0; dv < 3; dv++) begin
      set_div(7'(dv * dv + dv));
      for (int s = 0; s < 4; s++)
        for (int u = 0; u < 2; u++)
          for (int o = 0; o < 2; o++)
            xfer(2'(s), u[0], o[0], 1'b0, rnd9(), rnd9());
    end

    // R4: narrow write while enabled starts and keeps divider and bit 8
    set_div(7'd1);
    xfer(2'd2, 1'b1, 1'b0, 1'b0, 9'h155, 9'h1FF);
    xfer(2'd2, 1'b1, 1'b1, 1'b1, 9'h03C, 9'h1A6);
    xfer(2'd0, 1'b0, 1'b1, 1'b1, 9'h0FF, 9'h1FF);

    // R2: 9-bit code without capability drops the ninth bit
    xfer(2'd2, 1'b0, 1'b0, 1'b0, 9'h1FF, 9'h1FF);

    // R6: largest divider
    set_div(7'd127);
    xfer(2'd1, 1'b0, 1'b0, 1'b0, 9'h0A5, 9'h05A);

    // R5: write during a transfer does not restart it
    set_div(7'd1);
    len_sel = 2'd1; uart9_en = 1'b0; msb_first = 1'b0; chan_en = 1'b1; ser_in = 1'b1;
    l = 8;
    wr(1'b1, 16'h0033);
    p0 = pcnt;
    repeat (3) @(negedge clk);
    v = 9'h1E7;
    wr(1'b1, {7'd0, v});
    chk(bus_rdata == {7'd1, v}, "R5", "buffer write while busy", bus_rdata, {7'd1, v});
    chk(busy == 1'b1, "R5", "still busy after mid write", busy, 1);
    for (int g = 0; g < 200 && !done; g++) @(negedge clk);
    chk(pcnt - p0 == l * 4, "R5", "timing unchanged by mid write", pcnt - p0, l * 4);
    chk(bus_rdata == 16'h02FF, "R9", "receive overwrites buffer", bus_rdata, 16'h02FF);
    @(negedge clk);
    chk(bit_tick == 1'b0 && busy == 1'b0, "R6", "no tick when idle", {bit_tick, busy}, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule